// File: doc/BRIEF.md
# Packed Integer-to-Double Converter

This block turns a 64-bit operand that carries two signed 32-bit integers into a 128-bit result that carries two IEEE-754 double-precision values. Each integer lane is converted on its own and lands in the matching half of the result. Any 32-bit integer fits in a 53-bit significand, so the conversion is always exact. It never rounds and it raises no floating-point exceptions.

A one-cycle start pulse launches an operation. A source-kind input marks the operand as coming from a register or from memory. A register-sourced operation also switches a separate legacy floating-point stack unit into integer-register mode. It does this with a one-cycle strobe that tells the stack unit to zero its top pointer and mark every tag valid. If that unit has a pending exception when the operation starts, the block first asks for it to be serviced and waits for an acknowledge. A memory-sourced operation leaves the stack unit alone. When the result registers have loaded, a done pulse follows one cycle later.

Top module: `pk_i2d_cvt`

## Requirements
- R1: result_o[63:0] is the exact double-precision value of the signed integer in the src_i[31:0] captured at start.
- R2: result_o[127:64] is the exact double-precision value of the signed integer in the src_i[63:32] captured at start.
- R3: A zero lane produces +0.0, with all 64 bits zero.
- R4: The lane value -2147483648 produces 64'hC1E0000000000000: sign 1, biased exponent 1054, fraction 0.
- R5: Every nonzero lane has its sign bit (bit 63 of the lane) equal to the integer's bit 31, and its biased exponent (bits 62:52) equal to 1023 plus the position of the leading one of the magnitude.
- R6: done_o is a single-cycle pulse. It is high in the cycle after the cycle in which the result registers load. On the memory path, or on the register path with nothing pending, that is the second cycle after the start edge.
- R7: When src_is_reg_i is 0 at start, neither stk_reset_o nor exc_service_req_o asserts, whatever exc_pending_i is.
- R8: A register-sourced operation asserts stk_reset_o for exactly one cycle, the cycle just before done_o.
- R9: When src_is_reg_i and exc_pending_i are both 1 at start, exc_service_req_o stays high and stk_reset_o and done_o stay low until exc_ack_i is sampled high. stk_reset_o then pulses in the next cycle and done_o follows it.
- R10: A start pulse that arrives while an operation is in flight is ignored. The source is not captured and no extra done is produced.
- R11: result_o holds its value from the done pulse until the next operation loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle launch pulse, accepted only when idle |
| src_is_reg_i | input | 1 | 1 = operand from register file, 0 = from memory |
| src_i | input | 64 | Two packed signed 32-bit integers |
| exc_pending_i | input | 1 | Stack unit has an unserviced exception (sampled at start) |
| exc_ack_i | input | 1 | Stack unit reports the exception has been serviced |
| exc_service_req_o | output | 1 | Request to service the pending stack exception |
| stk_reset_o | output | 1 | One-cycle strobe: zero the stack top pointer, mark all tags valid |
| result_o | output | 128 | Two packed double-precision values |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume three things. exc_ack_i is raised only while exc_service_req_o is high. exc_pending_i has meaning only in the cycle in which start is accepted. All inputs are known after reset. The bench drives the acknowledge only inside a service request window. It holds start for a single cycle except in the deliberate in-flight start case. Lane expectations come from the simulator's own integer-to-real conversion: powers of two, their negations, all-ones runs, zero, the most negative integer and a pseudo-random stream, on both source kinds.

// File: rtl/pk_i2d_pkg.sv
package pk_i2d_pkg;
  localparam int INT_W  = 32;
  localparam int EXP_W  = 11;
  localparam int FRAC_W = 52;
  localparam int DBL_W  = 1 + EXP_W + FRAC_W;
  localparam int BIAS   = 1023;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_WAIT_EXC = 2'd1,
    ST_CONV     = 2'd2,
    ST_DONE     = 2'd3
  } cvt_state_e;

  // Magnitude kept as unsigned INT_W bits, so the most negative value does not overflow
  function automatic logic [INT_W-1:0] lane_mag(input logic [INT_W-1:0] v);
    return v[INT_W-1] ? (~v + INT_W'(1)) : v;
  endfunction

  function automatic int lead_pos(input logic [INT_W-1:0] m);
    int p;
    p = 0;
    for (int i = 0; i < INT_W; i++)
      if (m[i]) p = i;
    return p;
  endfunction

  function automatic logic [DBL_W-1:0] int_to_dbl(input logic [INT_W-1:0] v);
    logic [INT_W-1:0]  m;
    logic [FRAC_W:0]   sh;
    logic [EXP_W-1:0]  e;
    int                p;
    m = lane_mag(v);
    if (m == '0) return '0;
    p  = lead_pos(m);
    sh = (FRAC_W+1)'(m) << (FRAC_W - p);
    e  = EXP_W'(BIAS + p);
    return {v[INT_W-1], e, sh[FRAC_W-1:0]};
  endfunction
endpackage

// File: rtl/pk_i2d_lane.sv
module pk_i2d_lane
  import pk_i2d_pkg::*;
(
  input  logic [INT_W-1:0] int_i,
  output logic [DBL_W-1:0] dbl_o
);
  logic [INT_W-1:0] mag_w;
  int               lead_w;

  assign mag_w  = lane_mag(int_i);
  assign lead_w = lead_pos(mag_w);
  assign dbl_o  = int_to_dbl(int_i);

  always_comb begin
    if (!$isunknown(int_i)) begin
      if (int_i == '0) begin
        AST_ZERO_POSITIVE: assert (dbl_o == '0); // R3
      end else begin
        AST_SIGN_FOLLOWS: assert (dbl_o[DBL_W-1] == int_i[INT_W-1]); // R5
        AST_EXP_MATCHES_LEAD: assert (int'(dbl_o[DBL_W-2:FRAC_W]) == BIAS + lead_w); // R5
      end
    end
  end
endmodule

// File: rtl/pk_i2d_seq.sv
module pk_i2d_seq
  import pk_i2d_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic src_is_reg_i,
  input  logic exc_pending_i,
  input  logic exc_ack_i,
  output logic capture_o,
  output logic load_o,
  output logic exc_service_req_o,
  output logic stk_reset_o,
  output logic done_o
);
  cvt_state_e state_q;
  logic       kind_reg_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      kind_reg_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          kind_reg_q <= src_is_reg_i;
          state_q    <= (src_is_reg_i && exc_pending_i) ? ST_WAIT_EXC : ST_CONV;
        end
        ST_WAIT_EXC: if (exc_ack_i) state_q <= ST_CONV;
        ST_CONV:     state_q <= ST_DONE;
        default:     state_q <= ST_IDLE;
      endcase
    end
  end

  assign capture_o         = (state_q == ST_IDLE) && start_i;
  assign load_o            = (state_q == ST_CONV);
  assign stk_reset_o       = (state_q == ST_CONV) && kind_reg_q;
  assign exc_service_req_o = (state_q == ST_WAIT_EXC);
  assign done_o            = (state_q == ST_DONE);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_STROBE_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stk_reset_o |=> (done_o && !stk_reset_o)); // R8
  AST_HOLD_WHILE_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    exc_service_req_o |-> (!done_o && !stk_reset_o)); // R9
  AST_EXC_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_service_req_o && exc_ack_i) |=> stk_reset_o); // R9
  AST_MEM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_o && !src_is_reg_i) |=> (!exc_service_req_o && !stk_reset_o)); // R7
endmodule

// File: rtl/pk_i2d_cvt.sv
module pk_i2d_cvt
  import pk_i2d_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     src_is_reg_i,
  input  logic [LANES*INT_W-1:0]   src_i,
  input  logic                     exc_pending_i,
  input  logic                     exc_ack_i,
  output logic                     exc_service_req_o,
  output logic                     stk_reset_o,
  output logic [LANES*DBL_W-1:0]   result_o,
  output logic                     done_o
);
  localparam int SRC_W = LANES * INT_W;
  localparam int RES_W = LANES * DBL_W;

  logic             capture_w;
  logic             load_w;
  logic [SRC_W-1:0] src_q;
  logic [RES_W-1:0] conv_w;

  pk_i2d_seq u_seq (
    .clk               (clk),
    .rst_n             (rst_n),
    .start_i           (start_i),
    .src_is_reg_i      (src_is_reg_i),
    .exc_pending_i     (exc_pending_i),
    .exc_ack_i         (exc_ack_i),
    .capture_o         (capture_w),
    .load_o            (load_w),
    .exc_service_req_o (exc_service_req_o),
    .stk_reset_o       (stk_reset_o),
    .done_o            (done_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         src_q <= '0;
    else if (capture_w) src_q <= src_i;
  end

  // Lane k of the source feeds lane k of the result
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pk_i2d_lane u_lane (
      .int_i (src_q[k*INT_W +: INT_W]),
      .dbl_o (conv_w[k*DBL_W +: DBL_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      result_o <= '0;
    else if (load_w) result_o <= conv_w;
  end

  AST_DONE_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load_w |=> done_o); // R6
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_w |=> $stable(result_o)); // R11
  AST_NO_CAPTURE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && (load_w || done_o || exc_service_req_o)) |=> $stable(src_q)); // R10
endmodule

// File: tb/pk_i2d_cvt_tb_top.sv
`timescale 1ns/1ps
module pk_i2d_cvt_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         src_is_reg_i = 1'b0;
  logic [63:0]  src_i = '0;
  logic         exc_pending_i = 1'b0;
  logic         exc_ack_i = 1'b0;
  logic         exc_service_req_o;
  logic         stk_reset_o;
  logic [127:0] result_o;
  logic         done_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  pk_i2d_cvt dut_i (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .src_is_reg_i (src_is_reg_i),
    .src_i (src_i), .exc_pending_i (exc_pending_i), .exc_ack_i (exc_ack_i),
    .exc_service_req_o (exc_service_req_o), .stk_reset_o (stk_reset_o),
    .result_o (result_o), .done_o (done_o)
  );

  function automatic logic [63:0] ref_dbl(input logic [31:0] v);
    int s;
    s = int'(v);
    return $realtobits(real'(s));
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic run_op(input logic [63:0] s, input bit reg_src, input bit pend, input int ack_wait);
    start_i = 1'b1; src_i = s; src_is_reg_i = reg_src; exc_pending_i = pend;
    step();
    start_i = 1'b0; exc_pending_i = 1'b0; src_i = ~s;
    if (reg_src && pend) begin
      for (int k = 0; k < ack_wait; k++) begin
        chk("R9 req", 128'(exc_service_req_o), 128'(1));
        chk("R9 held", 128'({done_o, stk_reset_o}), 128'(0));
        step();
      end
      chk("R9 req", 128'(exc_service_req_o), 128'(1));
      exc_ack_i = 1'b1;
      step();
      exc_ack_i = 1'b0;
    end
    chk(reg_src ? "R8 strobe" : "R7 strobe", 128'(stk_reset_o), 128'(reg_src));
    chk("R7 req", 128'(exc_service_req_o), 128'(0));
    chk("R6 early", 128'(done_o), 128'(0));
    step();
    chk("R6 done", 128'(done_o), 128'(1));
    chk("R8 single", 128'(stk_reset_o), 128'(0));
    chk("R1 low lane", 128'(result_o[63:0]), 128'(ref_dbl(s[31:0])));
    chk("R2 high lane", 128'(result_o[127:64]), 128'(ref_dbl(s[63:32])));
    step();
    chk("R6 pulse", 128'(done_o), 128'(0));
    chk("R11 hold", result_o, {ref_dbl(s[63:32]), ref_dbl(s[31:0])});
  endtask

  initial begin
    logic [31:0] lf;
    logic [63:0] a;
    step(); step();
    chk("reset result", result_o, 128'(0));
    chk("reset ctl", 128'({done_o, stk_reset_o, exc_service_req_o}), 128'(0));
    rst_n = 1'b1;
    step();

    // R3 / R4 fixed corners
    run_op({32'h8000_0000, 32'h0000_0000}, 1'b0, 1'b0, 0);
    chk("R3 zero", 128'(result_o[63:0]), 128'(0));
    chk("R4 min int", 128'(result_o[127:64]), 128'(64'hC1E0_0000_0000_0000));

    // R5 sweep: powers of two, negations, all-ones runs, both source kinds
    for (int k = 0; k < 32; k++) begin
      logic [31:0] p;
      p = 32'h1 << k;
      run_op({p, -p}, k[0], 1'b0, 0);
      run_op({p - 32'h1, ~p}, 1'b0, 1'b1, 0);     // R7 pending ignored on memory path
    end

    // R9 pending exception with varying service latency
    for (int w = 0; w < 6; w++) run_op({32'(w * 7919), 32'(-w * 104729)}, 1'b1, 1'b1, w);

    // pseudo-random values
    lf = 32'hACE1_1234;
    for (int n = 0; n < 60; n++) begin
      logic [31:0] hi;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      hi = lf * 32'h9E37_79B9;
      run_op({hi, lf}, n[0], n[1], n % 3);
    end

    // R10: start during an operation is ignored
    a = 64'h7FFF_FFFF_FFFF_FFFF;
    start_i = 1'b1; src_i = a; src_is_reg_i = 1'b0;
    step();
    src_i = 64'h1234_5678_0000_0001; src_is_reg_i = 1'b1; exc_pending_i = 1'b1;
    step();
    start_i = 1'b0; exc_pending_i = 1'b0;
    chk("R10 done", 128'(done_o), 128'(1));
    chk("R10 result", result_o, {ref_dbl(a[63:32]), ref_dbl(a[31:0])});
    step();
    chk("R10 no strobe", 128'({stk_reset_o, exc_service_req_o, done_o}), 128'(0));
    step();
    chk("R10 no extra done", 128'({stk_reset_o, done_o}), 128'(0));
    chk("R10 R11 kept", result_o, {ref_dbl(a[63:32]), ref_dbl(a[31:0])});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule